// File: doc/BRIEF.md
# Breakpoint Match Status Unit

This block watches a stream of memory accesses against four programmable address watchpoints. Each access arrives as a start address, a byte count of one to ten, a kind (instruction fetch, data read or data write) and two flags. The flags say whether the access is one iteration of a repeated string operation and whether it is the final iteration. Each watchpoint covers an aligned window of 1, 2, 4 or 8 bytes and is armed for one kind of traffic. A separate enable register decides which watchpoints may call the debug trap.

When an access touches at least one enabled watchpoint, the unit records in a sticky status word every watchpoint the access touched, enabled or not, and raises a one-cycle trap request. During a repeated string operation the status bits gather across all iterations, and the trap is held back until the final iteration. An access that runs across a 64-byte line boundary is tested on both sides of the boundary. Every byte of a ten-byte store is covered. Software clears the gathered bits by writing ones to the match field.

Top module: `bkpt_match_unit`

## Requirements
- R1: The status word reads as bits 3:0 = match flags of watchpoints 0..3 (bit n for watchpoint n), bits 15:12 = 0, all other bits = 1; after reset it reads FFFF0FF0h and trap_req is 0.
- R2: When an access touches at least one enabled watchpoint, the status bit of every touched watchpoint is set, including ones whose enable bit is 0. An access that touches only disabled watchpoints leaves the status word unchanged and raises no trap.
- R3: A watchpoint's window starts at its programmed address rounded down to its length and spans the length, with length code 0/1/2/3 meaning 1/2/4/8 bytes. An access touches it when any of its bytes lies inside the window.
- R4: Watchpoint kind code 0 matches only fetches, 1 only writes, 2 reads or writes, and 3 nothing. Access kind code 0 is a fetch, 1 a read and 2 a write.
- R5: Status bits are sticky. Within a repeated operation, a later iteration that touches fewer watchpoints leaves earlier bits set (0 and 2 touched, then only 0, still reads FFFF0FF5h).
- R6: An access whose bytes cross a 64-byte line boundary is tested on both the low and the high part. A match in the high part alone sets status and raises the trap.
- R7: Access sizes of 1 to 10 bytes are supported, and a watchpoint on the ninth or tenth byte of a ten-byte write is detected.
- R8: trap_req is a one-cycle pulse in the cycle after a non-repeated access that touched an enabled watchpoint. For a repeated operation it stays low on iterations without acc_last, and pulses after the final iteration if any iteration of the run touched an enabled watchpoint.
- R9: A status write clears all match bits only when sts_wdata is all ones, and is otherwise ignored. Matches of an access in the same cycle as a clearing write are kept.
- R10: Watchpoint configuration and enable writes take effect for accesses in the following cycle. Status changes appear in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one watchpoint's configuration |
| cfg_idx | input | 2 | Watchpoint selected by cfg_we |
| cfg_addr | input | 32 | Watched address (rounded down to the length) |
| cfg_len | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 bytes |
| cfg_kind | input | 2 | Kind code: 0 fetch, 1 write, 2 read/write, 3 off |
| ctl_we | input | 1 | Write the enable register |
| ctl_en | input | 4 | Per-watchpoint trap enables |
| sts_we | input | 1 | Software write to the status match field |
| sts_wdata | input | 4 | Write data; all ones clears the match bits |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | First byte address of the access |
| acc_size | input | 4 | Byte count, 1 to 10 (0 is treated as no access) |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| acc_rep | input | 1 | Access is an iteration of a repeated string operation |
| acc_last | input | 1 | This iteration is the last of the repeated operation |
| sts_rdata | output | 32 | Status word |
| trap_req | output | 1 | Debug trap request pulse |

## Verification
The bench targets four kinds of corner case. The first is a repeated run where a later iteration touches a subset of the earlier watchpoints: a design that reloads the status instead of merging it drops bit 2 and reads FFFF0FF1h. The second is a line-crossing access whose only match lies above the boundary: a design that tests only the low part misses both the status bit and the trap. The third is a ten-byte write that touches a watchpoint only on byte ten, next to a nine-byte write that must not: truncating the byte count misses the first, and an off-by-one in the end address falsely hits on the second. The last covers disabled-only matches, partial clear patterns and a clear that coincides with a new match: a wrong gate records stale bits, clears on any write or loses the fresh match.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      WATCH_FETCH = 2'd0,
      WATCH_WRITE = 2'd1,
      WATCH_RDWR  = 2'd2,
      WATCH_OFF   = 2'd3
   } watch_kind_e;

   typedef struct packed {
      logic [1:0]  len_code;
      watch_kind_e kind;
   } watch_attr_t;

   // Whether traffic of kind a can trip a watchpoint armed for kind w
   function automatic logic kind_match(watch_kind_e w, acc_kind_e a);
      logic ok;
      case (w)
         WATCH_FETCH: ok = (a == ACC_FETCH);
         WATCH_WRITE: ok = (a == ACC_WRITE);
         WATCH_RDWR:  ok = (a == ACC_READ) || (a == ACC_WRITE);
         default:     ok = 1'b0;
      endcase
      return ok;
   endfunction

   // Window length in bytes from a length code
   function automatic logic [3:0] len_bytes(logic [1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/bkpt_access_split.sv
module bkpt_access_split #(
   parameter  int ADDR_W      = 32,
   parameter  int SIZE_W      = 4,
   parameter  int LINE_BYTES  = 64,
   parameter  int SPLIT_LINES = 1,
   localparam int EW          = ADDR_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic [EW-1:0]     lo_start,
   output logic [EW-1:0]     lo_end,
   output logic [EW-1:0]     hi_start,
   output logic [EW-1:0]     hi_end,
   output logic              hi_valid
);
   localparam int LSB = $clog2(LINE_BYTES);

   logic [EW-1:0] last_b;

   assign lo_start = {1'b0, addr};
   assign last_b   = lo_start + EW'(size) - EW'(1);

   generate
      if (SPLIT_LINES != 0) begin : g_split
         logic [EW-1:0] line_end;
         assign line_end = {1'b0, addr[ADDR_W-1:LSB], {LSB{1'b1}}};
         assign hi_valid = (last_b > line_end);
         assign lo_end   = hi_valid ? line_end : last_b;
         assign hi_start = line_end + EW'(1);
         assign hi_end   = last_b;
      end else begin : g_flat
         assign hi_valid = 1'b0;
         assign lo_end   = last_b;
         assign hi_start = '0;
         assign hi_end   = '0;
      end
   endgenerate

endmodule

// File: rtl/bkpt_range_cmp.sv
module bkpt_range_cmp #(
   parameter int EW = 33
) (
   input  logic [EW-1:0] a_lo,
   input  logic [EW-1:0] a_hi,
   input  logic [EW-1:0] b_lo,
   input  logic [EW-1:0] b_hi,
   output logic          ovl
);
   assign ovl = (a_lo <= b_hi) && (a_hi >= b_lo);
endmodule

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
   import bkpt_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int NPARTS = 2,
   localparam int EW     = ADDR_W + 1
) (
   input  logic [ADDR_W-1:0]            base,
   input  watch_attr_t                  attr,
   input  logic [1:0]                   acc_kind,
   input  logic [NPARTS-1:0][EW-1:0]    part_lo,
   input  logic [NPARTS-1:0][EW-1:0]    part_hi,
   input  logic [NPARTS-1:0]            part_ok,
   output logic                         hit
);
   logic [EW-1:0]     win_lo;
   logic [EW-1:0]     win_hi;
   logic [NPARTS-1:0] ovl;

   assign win_lo = {1'b0, base};
   assign win_hi = win_lo + EW'(len_bytes(attr.len_code)) - EW'(1);

   for (genvar p = 0; p < NPARTS; p++) begin : g_part
      bkpt_range_cmp #(.EW(EW)) u_rc (
         .a_lo (part_lo[p]),
         .a_hi (part_hi[p]),
         .b_lo (win_lo),
         .b_hi (win_hi),
         .ovl  (ovl[p])
      );
   end

   assign hit = kind_match(attr.kind, acc_kind_e'(acc_kind)) && (|(ovl & part_ok));

endmodule

// File: rtl/bkpt_status_acc.sv
module bkpt_status_acc #(
   parameter int NUM_BP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_fire,
   input  logic              acc_rep,
   input  logic              acc_last,
   input  logic [NUM_BP-1:0] hit,
   input  logic [NUM_BP-1:0] en,
   input  logic              clr,
   output logic [NUM_BP-1:0] bits,
   output logic              trap_req
);
   logic pend_q;
   logic en_hit;
   logic run_open;

   assign en_hit   = |(hit & en);
   assign run_open = acc_rep && !acc_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits     <= '0;
         pend_q   <= 1'b0;
         trap_req <= 1'b0;
      end else begin
         bits <= (clr ? '0 : bits) | ((acc_fire && en_hit) ? hit : '0);
         if (acc_fire) begin
            if (run_open) begin
               pend_q   <= pend_q | en_hit;
               trap_req <= 1'b0;
            end else begin
               pend_q   <= 1'b0;
               trap_req <= pend_q | en_hit;
            end
         end else begin
            trap_req <= 1'b0;
         end
      end
   end

   // R5: without a clear, no recorded bit is ever lost
   a_r5_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((bits & $past(bits)) == $past(bits)));

   // R8: no trap while a repeated run is still open
   a_r8_quiet_midrun: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && run_open) |=> !trap_req);

   // R8: a trap always follows an access
   a_r8_trap_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(acc_fire));

   // R2: disabled-only matches leave status and trap alone
   a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && ((hit & en) == '0) && !pend_q && !clr) |=> (!trap_req && $stable(bits)));

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
   import bkpt_pkg::*;
#(
   parameter  int                ADDR_W      = 32,
   parameter  int                NUM_BP      = 4,
   parameter  int                SIZE_W      = 4,
   parameter  int                MAX_SIZE    = 10,
   parameter  int                LINE_BYTES  = 64,
   parameter  int                SPLIT_LINES = 1,
   parameter  int                STS_W       = 32,
   parameter  logic [STS_W-1:0]  STS_FILL    = 32'hFFFF_0FF0,
   localparam int                IDX_W       = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_len,
   input  logic [1:0]        cfg_kind,
   input  logic              ctl_we,
   input  logic [NUM_BP-1:0] ctl_en,
   input  logic              sts_we,
   input  logic [NUM_BP-1:0] sts_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [1:0]        acc_kind,
   input  logic              acc_rep,
   input  logic              acc_last,
   output logic [STS_W-1:0]  sts_rdata,
   output logic              trap_req
);
   localparam int EW     = ADDR_W + 1;
   localparam int NPARTS = 2;
   localparam int LSB    = $clog2(LINE_BYTES);

   // Elaboration-time parameter checks
   if (NUM_BP < 1 || NUM_BP > 4) begin : g_chk_nbp
      $error("NUM_BP must be 1..4");
   end
   if ((1 << LSB) != LINE_BYTES) begin : g_chk_line
      $error("LINE_BYTES must be a power of two");
   end
   if (MAX_SIZE > LINE_BYTES || MAX_SIZE >= (1 << SIZE_W)) begin : g_chk_size
      $error("MAX_SIZE must fit SIZE_W and one line");
   end
   if (STS_W < 16 || STS_FILL[NUM_BP-1:0] != '0) begin : g_chk_sts
      $error("status word too narrow or fill overlaps match field");
   end

   // Watchpoint configuration
   logic [NUM_BP-1:0][ADDR_W-1:0] base_q;
   watch_attr_t [NUM_BP-1:0]      attr_q;
   logic [NUM_BP-1:0]             en_q;
   logic [ADDR_W-1:0]             align_mask;

   assign align_mask = ~(ADDR_W'(len_bytes(cfg_len)) - ADDR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         en_q   <= '0;
         for (int i = 0; i < NUM_BP; i++) begin
            attr_q[i] <= '{len_code: 2'd0, kind: WATCH_OFF};
         end
      end else begin
         if (cfg_we && (int'(cfg_idx) < NUM_BP)) begin
            base_q[cfg_idx] <= cfg_addr & align_mask;
            attr_q[cfg_idx] <= '{len_code: cfg_len, kind: watch_kind_e'(cfg_kind)};
         end
         if (ctl_we) begin
            en_q <= ctl_en;
         end
      end
   end

   // Access split at the line boundary
   logic                     acc_fire;
   logic [EW-1:0]            lo_start, lo_end, hi_start, hi_end;
   logic                     hi_valid;
   logic [NPARTS-1:0][EW-1:0] part_lo, part_hi;
   logic [NPARTS-1:0]        part_ok;

   assign acc_fire = acc_valid && (acc_size != '0);

   bkpt_access_split #(
      .ADDR_W      (ADDR_W),
      .SIZE_W      (SIZE_W),
      .LINE_BYTES  (LINE_BYTES),
      .SPLIT_LINES (SPLIT_LINES)
   ) u_split (
      .addr     (acc_addr),
      .size     (acc_size),
      .lo_start (lo_start),
      .lo_end   (lo_end),
      .hi_start (hi_start),
      .hi_end   (hi_end),
      .hi_valid (hi_valid)
   );

   assign part_lo = {hi_start, lo_start};
   assign part_hi = {hi_end, lo_end};
   assign part_ok = {hi_valid, 1'b1};

   // R6: the high part always begins on a line boundary
   a_r6_high_on_line: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && hi_valid) |-> (hi_start[LSB-1:0] == '0));

   // R7: the two parts together hold exactly acc_size bytes
   a_r7_bytes_covered: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire |-> ((lo_end - lo_start + EW'(1))
                    + (hi_valid ? (hi_end - hi_start + EW'(1)) : EW'(0))) == EW'(acc_size));

   // Comparators
   logic [NUM_BP-1:0] hit;

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      bkpt_comparator #(.ADDR_W(ADDR_W), .NPARTS(NPARTS)) u_cmp (
         .base     (base_q[i]),
         .attr     (attr_q[i]),
         .acc_kind (acc_kind),
         .part_lo  (part_lo),
         .part_hi  (part_hi),
         .part_ok  (part_ok),
         .hit      (hit[i])
      );
   end

   // Status and trap
   logic [NUM_BP-1:0] sts_bits;
   logic              sts_clr;

   assign sts_clr = sts_we && (&sts_wdata);

   bkpt_status_acc #(.NUM_BP(NUM_BP)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_fire (acc_fire),
      .acc_rep  (acc_rep),
      .acc_last (acc_last),
      .hit      (hit),
      .en       (en_q),
      .clr      (sts_clr),
      .bits     (sts_bits),
      .trap_req (trap_req)
   );

   always_comb begin
      sts_rdata               = STS_FILL;
      sts_rdata[NUM_BP-1:0]   = sts_bits;
   end

endmodule

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_idx = 0;
   logic [31:0] cfg_addr = 0;
   logic [1:0]  cfg_len = 0;
   logic [1:0]  cfg_kind = 0;
   logic        ctl_we = 0;
   logic [3:0]  ctl_en = 0;
   logic        sts_we = 0;
   logic [3:0]  sts_wdata = 0;
   logic        acc_valid = 0;
   logic [31:0] acc_addr = 0;
   logic [3:0]  acc_size = 0;
   logic [1:0]  acc_kind = 0;
   logic        acc_rep = 0;
   logic        acc_last = 0;
   logic [31:0] sts_rdata;
   logic        trap_req;

   always #4 clk = ~clk;

   bkpt_match_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
      .cfg_len(cfg_len), .cfg_kind(cfg_kind),
      .ctl_we(ctl_we), .ctl_en(ctl_en),
      .sts_we(sts_we), .sts_wdata(sts_wdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_kind(acc_kind), .acc_rep(acc_rep), .acc_last(acc_last),
      .sts_rdata(sts_rdata), .trap_req(trap_req)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R1";

   // Reference model state
   longint unsigned m_base[4];
   int              m_len[4];
   int              m_kind[4];
   bit [3:0]        m_en, m_sts;
   bit              m_pend, exp_trap;

   function automatic bit kind_ok(int w, int a);
      return (w == 0 && a == 0) || (w == 1 && a == 2) || (w == 2 && (a == 1 || a == 2));
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic compare();
      logic [31:0] exp_sts;
      exp_sts = 32'hFFFF0FF0 | {28'h0, m_sts};
      n_chk++;
      if (sts_rdata !== exp_sts || trap_req !== exp_trap) begin
         n_fail++;
         $display("FAIL %s: sts_rdata=%h trap_req=%b expected sts_rdata=%h trap_req=%b",
                  cur_req, sts_rdata, trap_req, exp_sts, exp_trap);
      end
   endtask

   // Apply current inputs for one clock, advance model, compare
   task automatic step();
      bit [3:0] hit;
      bit       en_hit, clr, fire;
      hit  = 4'h0;
      fire = acc_valid && (acc_size != 0);
      if (fire) begin
         for (int b = 0; b < int'(acc_size); b++) begin
            longint unsigned ba;
            ba = longint'(acc_addr) + b;
            for (int i = 0; i < 4; i++) begin
               if (ba >= m_base[i] && ba < m_base[i] + m_len[i] && kind_ok(m_kind[i], int'(acc_kind)))
                  hit[i] = 1'b1;
            end
         end
      end
      en_hit = |(hit & m_en);
      clr    = sts_we && (sts_wdata == 4'hF);
      if (clr) m_sts = 4'h0;
      if (fire && en_hit) m_sts |= hit;
      exp_trap = 1'b0;
      if (fire) begin
         if (acc_rep && !acc_last) begin
            m_pend |= en_hit;
         end else begin
            exp_trap = en_hit | m_pend;
            m_pend   = 1'b0;
         end
      end
      if (cfg_we) begin
         int l;
         l = 1 << cfg_len;
         m_len[cfg_idx]  = l;
         m_base[cfg_idx] = longint'(cfg_addr) & ~longint'(l - 1);
         m_kind[cfg_idx] = int'(cfg_kind);
      end
      if (ctl_we) m_en = ctl_en;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      cfg_we = 0; ctl_we = 0; sts_we = 0;
      acc_valid = 0; acc_rep = 0; acc_last = 0;
   endtask

   task automatic do_cfg(int i, int a, int l, int k);
      idle();
      cfg_we = 1; cfg_idx = 2'(i); cfg_addr = 32'(a); cfg_len = 2'(l); cfg_kind = 2'(k);
      step(); idle();
   endtask

   task automatic do_ctl(int e);
      idle(); ctl_we = 1; ctl_en = 4'(e); step(); idle();
   endtask

   task automatic do_clr(int d);
      idle(); sts_we = 1; sts_wdata = 4'(d); step(); idle();
   endtask

   task automatic do_acc(int a, int s, int k, bit rep, bit last);
      idle();
      acc_valid = 1; acc_addr = 32'(a); acc_size = 4'(s); acc_kind = 2'(k);
      acc_rep = rep; acc_last = last;
      step(); idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_base[i] = 0; m_len[i] = 1; m_kind[i] = 3;
      end
      m_en = 0; m_sts = 0; m_pend = 0; exp_trap = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      cur_req = "R1 reset state";
      compare();

      // R10 / R3: configuration with alignment (0x103 len 2 -> 0x102..0x103)
      cur_req = "R10 config";
      do_cfg(0, 'h100, 2, 2);
      do_cfg(2, 'h103, 1, 2);
      do_cfg(1, 'h180, 0, 2);
      do_ctl(4'b0001);

      // R2: enabled 0 and disabled 2 both reported -> FFFF0FF5, trap
      cur_req = "R2 all matches reported";
      do_acc('h100, 4, 1, 0, 0);
      cur_req = "R3 aligned window";
      do_acc('h104, 4, 1, 0, 0);

      // R9: partial write ignored, all-ones clears
      cur_req = "R9 partial write ignored";
      do_clr(4'h7);
      cur_req = "R9 clear";
      do_clr(4'hF);

      // R2: disabled-only match changes nothing
      cur_req = "R2 disabled only";
      do_acc('h180, 1, 1, 0, 0);

      // R5 / R8: repeated run keeps bits, trap only after last
      cur_req = "R5 rep iteration 1";
      do_acc('h102, 2, 1, 1, 0);
      cur_req = "R5 rep subset iteration";
      do_acc('h100, 1, 1, 1, 0);
      cur_req = "R8 rep last iteration";
      do_acc('h1A0, 2, 1, 1, 1);
      cur_req = "R8 trap pulse ends";
      step();

      // R4: write-only watchpoint ignores reads
      do_clr(4'hF);
      do_ctl(4'b1111);
      do_cfg(1, 'h13F, 0, 1);
      cur_req = "R4 read vs write-only";
      do_acc('h13E, 2, 1, 0, 0);
      cur_req = "R4 write hits write-only";
      do_acc('h13E, 2, 2, 0, 0);

      // R6: match only in the high part of a line-crossing write
      do_clr(4'hF);
      do_cfg(1, 'h180, 0, 1);
      do_cfg(3, 'h140, 3, 1);
      cur_req = "R6 high part only";
      do_acc('h13C, 8, 2, 0, 0);

      // R7: ninth byte vs tenth byte of a ten-byte write
      do_clr(4'hF);
      do_cfg(1, 'h209, 0, 1);
      cur_req = "R7 nine bytes miss";
      do_acc('h200, 9, 2, 0, 0);
      cur_req = "R7 tenth byte hit";
      do_acc('h200, 10, 2, 0, 0);
      cur_req = "R7 shifted miss";
      do_clr(4'hF);
      do_acc('h1FF, 10, 2, 0, 0);

      // R4: fetch watchpoint
      do_cfg(0, 'h300, 0, 0);
      cur_req = "R4 write vs fetch";
      do_acc('h300, 1, 2, 0, 0);
      cur_req = "R4 fetch hit";
      do_acc('h300, 1, 0, 0, 0);

      // R9: clear and new match in the same cycle
      cur_req = "R9 clear with match";
      idle();
      sts_we = 1; sts_wdata = 4'hF;
      acc_valid = 1; acc_addr = 32'h209; acc_size = 4'd1; acc_kind = 2'd2;
      step(); idle();

      // R8 / R10: random traffic against the model
      cur_req = "R8 R10 random";
      for (int k = 0; k < 1500; k++) begin
         int op;
         op = $urandom_range(9, 0);
         if (op == 0) begin
            do_cfg($urandom_range(3, 0), 'h100 + $urandom_range(127, 0),
                   $urandom_range(3, 0), $urandom_range(3, 0));
         end else if (op == 1) begin
            do_ctl($urandom_range(15, 0));
         end else if (op == 2) begin
            do_clr($urandom_range(15, 0));
         end else if (op <= 4) begin
            int n;
            n = $urandom_range(4, 1);
            for (int j = 0; j < n; j++) begin
               idle();
               acc_valid = 1;
               acc_addr  = 32'('h100 + $urandom_range(127, 0));
               acc_size  = 4'($urandom_range(10, 1));
               acc_kind  = 2'($urandom_range(2, 0));
               acc_rep   = 1;
               acc_last  = (j == n - 1);
               if ($urandom_range(3, 0) == 0) begin
                  cfg_we = 1; cfg_idx = 2'($urandom_range(3, 0));
                  cfg_addr = 32'('h100 + $urandom_range(127, 0));
                  cfg_len = 2'($urandom_range(3, 0)); cfg_kind = 2'($urandom_range(3, 0));
               end
               step();
            end
            idle();
         end else begin
            idle();
            acc_valid = 1;
            acc_addr  = 32'('h100 + $urandom_range(127, 0));
            acc_size  = 4'($urandom_range(10, 1));
            acc_kind  = 2'($urandom_range(2, 0));
            if ($urandom_range(3, 0) == 0) begin
               sts_we = 1; sts_wdata = 4'($urandom_range(15, 0));
            end
            step();
            idle();
         end
      end
      finish_run();
   end

endmodule